// File: doc/BRIEF.md
# UART Raw Interrupt Status Logic

This block holds the raw interrupt flags of a UART with transmit and receive FIFOs. It compares the FIFO fill levels against programmable trigger levels, and it watches the serializer's idle indication and two modem status inputs (DSR and DCD). When a condition occurs, the block sets a sticky flag. Software clears a flag by writing a one to its position in a clear strobe. The transmit and receive flags also clear by themselves when software refills the transmit FIFO or drains the receive FIFO past the trigger.

The FIFOs, the serializer and the register decode are outside the block. The block sees them only as level counts, a write strobe, a read strobe and an idle flag. It outputs the raw flag word and a single interrupt line. The interrupt line is the registered OR of the flags gated by a mask that the block stores. A parameter removes the modem flags, so that a UART instance without modem lines reads them as zero.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous active-low reset, `raw_status` and `irq` are 0. In `raw_status`, bit 5 is the transmit flag, bit 4 the receive flag, bit 3 the DSR flag and bit 2 the DCD flag. Bits 1 and 0 always read 0.
- R2: With `eot_mode`=0, the transmit flag sets when `tx_level` moves from above the effective trigger to at or below it between two clock edges. The effective trigger is `tx_trig` when `fifo_en`=1 and 0 when `fifo_en`=0. The flag is visible after the edge that samples the new level.
- R3: With `eot_mode`=1, level crossings do not set the transmit flag. The flag sets only when (`ser_idle`=1 and `tx_level`=0) becomes true. If that condition is still true right after reset, it does not set the flag.
- R4: The transmit flag clears when `clr_wr`=1 with `wdata[5]`=1. It also clears automatically. With `fifo_en`=1 it clears when `tx_level` rises from at or below `tx_trig` to above it. With `fifo_en`=0 it clears on a `tx_wr` strobe.
- R5: The receive flag sets when `rx_level` moves from below the effective trigger to at or above it. The effective trigger is `rx_trig` when `fifo_en`=1 and 1 when `fifo_en`=0.
- R6: The receive flag clears when `clr_wr`=1 with `wdata[4]`=1. It also clears automatically. With `fifo_en`=1 it clears when `rx_level` falls from at or above `rx_trig` to below it. With `fifo_en`=0 it clears on an `rx_rd` strobe.
- R7: `dsr_in` and `dcd_in` each pass through two synchronizing flops. Any change of a synchronized value sets its flag on the third edge after the input changes. A modem flag clears only through `clr_wr` with `wdata[3]` (DSR) or `wdata[2]` (DCD).
- R8: With `HAS_MODEM`=0, bits 3 and 2 of `raw_status` always read 0.
- R9: When a set condition and a clear fall on the same edge, the flag ends up set.
- R10: `mask_wr`=1 loads `wdata` into the mask register, which resets to 0. `irq` is the OR of `raw_status & mask`, registered, so it follows the flags one cycle later.
- R11: A level that stays past its trigger does not set a flag again after the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled (0: single-byte holding mode) |
| eot_mode | input | 1 | Transmit flag source: 0 level crossing, 1 end of transmission |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| tx_trig | input | LVL_W | Transmit trigger level |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_wr | input | 1 | Strobe: byte written to transmit side |
| rx_rd | input | 1 | Strobe: byte read from receive side |
| ser_idle | input | 1 | Serializer has shifted out its last bit |
| dsr_in | input | 1 | Asynchronous DSR modem input |
| dcd_in | input | 1 | Asynchronous DCD modem input |
| clr_wr | input | 1 | Strobe: write-one-to-clear of flags from `wdata` |
| mask_wr | input | 1 | Strobe: load mask from `wdata` |
| wdata | input | 6 | Write data for clear and mask |
| raw_status | output | 6 | Raw flag word |
| irq | output | 1 | Registered masked interrupt |

## Verification
The bench checks that a set condition and a clear strobe landing on the same edge leave the flag set. A design where clear wins would lose that event. It also checks that a level held past its trigger, or a held idle condition, does not set the flag again after a clear. A level-sensitive design would keep the flag stuck on. Switching `fifo_en` exercises both auto-clear paths and the substituted trigger values. A design that ignores the mode would miss the single-byte clears or set the flag at the wrong level. The bench also checks that the end-of-transmission source suppresses level crossings, that the modem flags survive auto-clear activity, and that the interrupt lags the flags by exactly one edge.

// File: rtl/uart_irq_pkg.sv
// Shared constants: width of the raw status word and the fixed flag positions.
package uart_irq_pkg;
    localparam int ST_W    = 6;
    localparam int TX_BIT  = 5;
    localparam int RX_BIT  = 4;
    localparam int DSR_BIT = 3;
    localparam int DCD_BIT = 2;
endpackage

// File: rtl/uart_irq_xdet.sv
// Threshold crossing detector for one FIFO level.
// "Above" means level > trig when INCL=0, or level >= trig when INCL=1.
// up_x pulses on the first cycle the level is above; dn_x pulses on the first cycle it is not.
// Assumes level and trig are synchronous to clk. After reset the previous state counts as not above.
module uart_irq_xdet #(
    parameter int LVL_W = 5,
    parameter bit INCL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             up_x,
    output logic             dn_x
);
    logic above;
    logic above_q;

    // Pick the comparison that matches the flag's direction.
    generate
        if (INCL) begin : g_ge
            assign above = (level >= trig);
        end else begin : g_gt
            assign above = (level > trig);
        end
    endgenerate

    // Remember the previous cycle's comparison result.
    always_ff @(posedge clk) begin
        if (!rst_n) above_q <= 1'b0;
        else        above_q <= above;
    end

    assign up_x = above & ~above_q;
    assign dn_x = ~above & above_q;
endmodule

// File: rtl/uart_irq_msync.sv
// Two-flop synchronizer for an asynchronous modem line, followed by a change detector.
// chg pulses for one cycle whenever the synchronized value differs from its previous value.
// Assumes the line resets low.
module uart_irq_msync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic chg
);
    logic meta_q, sync_q, prev_q;

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign chg = sync_q ^ prev_q;
endmodule

// File: rtl/uart_irq_status.sv
// Raw interrupt status for a UART: sticky flags for transmit, receive, DSR and DCD.
// A flag sets on its event and clears through write-one-to-clear or FIFO auto-clear; set beats clear.
// The interrupt line is the registered OR of flags gated by a stored mask.
// Assumes all strobes are single-cycle and synchronous to clk, except dsr_in/dcd_in, which are asynchronous.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter bit HAS_MODEM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             eot_mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tx_wr,
    input  logic             rx_rd,
    input  logic             ser_idle,
    input  logic             dsr_in,
    input  logic             dcd_in,
    input  logic             clr_wr,
    input  logic             mask_wr,
    input  logic [ST_W-1:0]  wdata,
    output logic [ST_W-1:0]  raw_status,
    output logic             irq
);
    localparam logic [LVL_W-1:0] RX_SINGLE = LVL_W'(1);

    logic [LVL_W-1:0] tx_t, rx_t;
    logic tx_up, tx_dn, rx_up, rx_dn;
    logic done_now, done_q, done_rise;
    logic tx_set, tx_clr, rx_set, rx_clr;
    logic [ST_W-1:0] set_v, clr_v, raw_q, mask_q;
    logic irq_q;
    logic [ST_W-1:0] w1c;

    // Effective triggers: single-byte holding mode uses fixed thresholds.
    assign tx_t = fifo_en ? tx_trig : '0;
    assign rx_t = fifo_en ? rx_trig : RX_SINGLE;

    uart_irq_xdet #(.LVL_W(LVL_W), .INCL(1'b0)) u_tx_det (
        .clk(clk), .rst_n(rst_n), .level(tx_level), .trig(tx_t),
        .up_x(tx_up), .dn_x(tx_dn)
    );

    uart_irq_xdet #(.LVL_W(LVL_W), .INCL(1'b1)) u_rx_det (
        .clk(clk), .rst_n(rst_n), .level(rx_level), .trig(rx_t),
        .up_x(rx_up), .dn_x(rx_dn)
    );

    // End-of-transmission: FIFO empty and serializer drained; the state after reset counts as seen.
    assign done_now = ser_idle && (tx_level == '0);
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b1;
        else        done_q <= done_now;
    end
    assign done_rise = done_now & ~done_q;

    assign w1c    = clr_wr ? wdata : '0;
    assign tx_set = eot_mode ? done_rise : tx_dn;
    assign tx_clr = w1c[TX_BIT] | (fifo_en ? tx_up : tx_wr);
    assign rx_set = rx_up;
    assign rx_clr = w1c[RX_BIT] | (fifo_en ? rx_dn : rx_rd);

    // Modem flags exist only when the parameter asks for them.
    generate
        if (HAS_MODEM) begin : g_modem
            logic dsr_chg, dcd_chg;
            uart_irq_msync u_dsr (.clk(clk), .rst_n(rst_n), .async_in(dsr_in), .chg(dsr_chg));
            uart_irq_msync u_dcd (.clk(clk), .rst_n(rst_n), .async_in(dcd_in), .chg(dcd_chg));
            assign set_v[DSR_BIT] = dsr_chg;
            assign set_v[DCD_BIT] = dcd_chg;
            assign clr_v[DSR_BIT] = w1c[DSR_BIT];
            assign clr_v[DCD_BIT] = w1c[DCD_BIT];

            // R7: a modem flag only drops through its own clear bit
            a_r7_modem_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_q[DSR_BIT] && !w1c[DSR_BIT]) |=> raw_q[DSR_BIT]);
        end else begin : g_no_modem
            assign set_v[DSR_BIT] = 1'b0;
            assign set_v[DCD_BIT] = 1'b0;
            assign clr_v[DSR_BIT] = 1'b0;
            assign clr_v[DCD_BIT] = 1'b0;

            // R8: absent modem flags read as zero
            a_r8_modem_absent: assert property (@(posedge clk) disable iff (!rst_n)
                raw_q[DSR_BIT:DCD_BIT] == 2'b00);
        end
    endgenerate

    assign set_v[TX_BIT] = tx_set;
    assign set_v[RX_BIT] = rx_set;
    assign clr_v[TX_BIT] = tx_clr;
    assign clr_v[RX_BIT] = rx_clr;
    assign set_v[1:0]    = 2'b00;
    assign clr_v[1:0]    = 2'b00;

    // Sticky flag update: a set in the same cycle as a clear keeps the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= set_v | (raw_q & ~clr_v);
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata;
    end

    // Registered masked interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_q & mask_q);
    end

    assign raw_status = raw_q;
    assign irq        = irq_q;

    // R1: unused positions never carry a flag
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q[1:0] == 2'b00);

    // R9: a transmit set event is never lost to a simultaneous clear
    a_r9_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> raw_q[TX_BIT]);

    // R9: same for receive
    a_r9_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> raw_q[RX_BIT]);

    // R3: in end-of-transmission mode only the drain event raises the transmit flag
    a_r3_eot_only: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_mode && !done_rise && !raw_q[TX_BIT]) |=> !raw_q[TX_BIT]);

    // R10: interrupt follows the masked flags one cycle later
    a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_q & mask_q)) |=> irq);
    a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw_q & mask_q)) |=> !irq);
endmodule

// File: tb/uart_irq_status_tb.sv
// Bench: behavioural reference model compared on every cycle, plus directed checks per requirement.
module uart_irq_status_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1, eot_mode = 1'b0;
    logic [4:0] tx_level = '0, tx_trig = 5'd4, rx_level = '0, rx_trig = 5'd8;
    logic tx_wr = 1'b0, rx_rd = 1'b0, ser_idle = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0;
    logic clr_wr = 1'b0, mask_wr = 1'b0;
    logic [5:0] wdata = '0;
    logic [5:0] raw, raw_nm;
    logic irq, irq_nm;

    int checks = 0;
    int failures = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    uart_irq_status #(.LVL_W(5), .HAS_MODEM(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_wr(tx_wr), .rx_rd(rx_rd), .ser_idle(ser_idle), .dsr_in(dsr_in), .dcd_in(dcd_in),
        .clr_wr(clr_wr), .mask_wr(mask_wr), .wdata(wdata), .raw_status(raw), .irq(irq)
    );

    uart_irq_status #(.LVL_W(5), .HAS_MODEM(1'b0)) dut_nm (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_wr(tx_wr), .rx_rd(rx_rd), .ser_idle(ser_idle), .dsr_in(dsr_in), .dcd_in(dcd_in),
        .clr_wr(clr_wr), .mask_wr(mask_wr), .wdata(wdata), .raw_status(raw_nm), .irq(irq_nm)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int p_txl, p_txt, p_rxl, p_rxt;
    bit p_done;
    bit [2:0] dsr_pipe, dcd_pipe;
    bit [5:0] m_raw, m_mask;
    bit m_irq;
    bit model_live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            p_txl = 0; p_txt = 0; p_rxl = 0; p_rxt = 1; p_done = 1;
            dsr_pipe = '0; dcd_pipe = '0; m_raw = '0; m_mask = '0; m_irq = 0;
        end else begin
            int tt, rt;
            bit tx_s, tx_c, rx_s, rx_c, dn, dsr_c, dcd_c;
            bit [5:0] w;
            tt = fifo_en ? int'(tx_trig) : 0;
            rt = fifo_en ? int'(rx_trig) : 1;
            w  = clr_wr ? wdata : 6'h00;
            dn = ser_idle && (tx_level == 0);
            if (eot_mode) tx_s = dn && !p_done;
            else          tx_s = (p_txl > p_txt) && (int'(tx_level) <= tt);
            tx_c = w[5] || (fifo_en ? ((p_txl <= p_txt) && (int'(tx_level) > tt)) : tx_wr);
            rx_s = (p_rxl < p_rxt) && (int'(rx_level) >= rt);
            rx_c = w[4] || (fifo_en ? ((p_rxl >= p_rxt) && (int'(rx_level) < rt)) : rx_rd);
            dsr_c = dsr_pipe[1] != dsr_pipe[2];
            dcd_c = dcd_pipe[1] != dcd_pipe[2];
            m_irq = |(m_raw & m_mask);
            if (tx_s) m_raw[5] = 1; else if (tx_c) m_raw[5] = 0;
            if (rx_s) m_raw[4] = 1; else if (rx_c) m_raw[4] = 0;
            if (dsr_c) m_raw[3] = 1; else if (w[3]) m_raw[3] = 0;
            if (dcd_c) m_raw[2] = 1; else if (w[2]) m_raw[2] = 0;
            if (mask_wr) m_mask = wdata;
            dsr_pipe = {dsr_pipe[1:0], dsr_in};
            dcd_pipe = {dcd_pipe[1:0], dcd_in};
            p_txl = tx_level; p_txt = tt; p_rxl = rx_level; p_rxt = rt; p_done = dn;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            check("R2/R4 tx flag vs model", raw[5], m_raw[5]);
            check("R5/R6 rx flag vs model", raw[4], m_raw[4]);
            check("R7 modem flags vs model", raw[3:2], m_raw[3:2]);
            check("R10 irq vs model", irq, m_irq);
            check("R8 no-modem word vs model", raw_nm, {m_raw[5:4], 4'b0000});
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic w1c(input logic [5:0] v);
        clr_wr = 1'b1; wdata = v; cyc(); clr_wr = 1'b0;
    endtask

    initial begin
        fork
            begin
                cyc(4);
                rst_n = 1'b1;
                cyc();
                model_live = 1'b1;
                check("R1 reset raw", raw, 0);
                check("R1 reset irq", irq, 0);

                // R2 level crossing in FIFO mode
                tx_level = 5'd10; cyc();
                check("R2 above trigger no set", raw[5], 0);
                tx_level = 5'd4; cyc();
                check("R2 falls to trigger sets", raw[5], 1);
                cyc(3);
                w1c(6'h20);
                check("R4 tx write-one-to-clear", raw[5], 0);
                cyc(2);
                check("R11 held level no re-set", raw[5], 0);
                tx_level = 5'd6; cyc();
                tx_level = 5'd3; cyc();
                check("R2 second crossing sets", raw[5], 1);
                tx_level = 5'd5; cyc();
                check("R4 refill past trigger clears", raw[5], 0);

                // R9 simultaneous set and clear
                tx_level = 5'd4; clr_wr = 1'b1; wdata = 6'h20; cyc(); clr_wr = 1'b0;
                check("R9 set wins over clear", raw[5], 1);
                w1c(6'h20);

                // FIFO disabled: trigger 0, single write clears
                fifo_en = 1'b0; tx_level = 5'd1; cyc();
                tx_level = 5'd0; cyc();
                check("R2 holding mode empties sets", raw[5], 1);
                tx_wr = 1'b1; cyc(); tx_wr = 1'b0;
                check("R4 single write clears", raw[5], 0);

                // R3 end of transmission
                fifo_en = 1'b1; eot_mode = 1'b1;
                tx_level = 5'd6; cyc();
                tx_level = 5'd4; cyc();
                check("R3 crossing ignored in eot mode", raw[5], 0);
                tx_level = 5'd0; cyc();
                check("R3 empty but busy no set", raw[5], 0);
                ser_idle = 1'b1; cyc();
                check("R3 drained sets", raw[5], 1);
                w1c(6'h20); cyc();
                check("R3 held idle no re-set", raw[5], 0);
                ser_idle = 1'b0; eot_mode = 1'b0; cyc();

                // R5/R6 receive
                rx_level = 5'd7; cyc();
                check("R5 below trigger no set", raw[4], 0);
                rx_level = 5'd8; cyc();
                check("R5 reaches trigger sets", raw[4], 1);
                rx_level = 5'd9; cyc();
                rx_level = 5'd7; cyc();
                check("R6 drain below trigger clears", raw[4], 0);
                rx_level = 5'd8; cyc();
                w1c(6'h10);
                check("R6 rx write-one-to-clear", raw[4], 0);
                cyc(2);
                check("R11 rx held no re-set", raw[4], 0);
                rx_level = 5'd0; cyc();
                fifo_en = 1'b0; rx_level = 5'd1; cyc();
                check("R5 holding mode one byte sets", raw[4], 1);
                rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
                check("R6 single read clears", raw[4], 0);
                fifo_en = 1'b1; rx_level = 5'd0; cyc();

                // R10 mask and registered interrupt
                mask_wr = 1'b1; wdata = 6'h10; cyc(); mask_wr = 1'b0;
                rx_level = 5'd8; cyc();
                check("R10 irq lags flag", irq, 0);
                cyc();
                check("R10 irq asserts", irq, 1);
                w1c(6'h10);
                check("R10 irq still high one cycle", irq, 1);
                cyc();
                check("R10 irq drops", irq, 0);
                tx_level = 5'd6; cyc();
                tx_level = 5'd3; cyc(3);
                check("R10 masked tx flag", raw[5], 1);
                check("R10 masked bit no irq", irq, 0);
                w1c(6'h20);

                // R7/R8 modem
                dsr_in = 1'b1; cyc(2);
                check("R7 synchronizer delay", raw[3], 0);
                cyc();
                check("R7 dsr change sets", raw[3], 1);
                check("R8 no-modem bits zero", raw_nm[3:2], 0);
                dsr_in = 1'b0; rx_rd = 1'b1; tx_wr = 1'b1; cyc(); rx_rd = 1'b0; tx_wr = 1'b0;
                cyc(2);
                check("R7 modem survives auto-clear", raw[3], 1);
                w1c(6'h08);
                check("R7 dsr write-one-to-clear", raw[3], 0);
                dcd_in = 1'b1; cyc(3);
                check("R7 dcd change sets", raw[2], 1);
                check("R8 no-modem after dcd", raw_nm[3:2], 0);
                check("R1 low bits zero", raw[1:0], 0);
                w1c(6'h04);
                check("R7 dcd write-one-to-clear", raw[2], 0);
                cyc(3);
                done_run = 1'b1;
            end
            begin
                cyc(20000);
                if (!done_run) begin
                    failures++;
                    $display("FAIL watchdog: actual=running expected=done");
                end
            end
        join_any
        model_live = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule